// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block is the digital input path of an 8-bit segmented resistor-ladder converter. It accepts a data word, a polarity control that can invert every bit, and an active-low latch enable. The three most significant bits are turned into a 7-line thermometer code whose lines carry equal weight. The five lower bits stay binary. Both groups pass through a hold stage that is transparent while the enable is low and frozen while it is high, so every ladder driver changes on the same edge.

The transparent hold stage is built from synchronous logic. A register follows the encoded word on each clock while the enable is low. The outputs show the live encoded word while the enable is low and the register contents while it is high. The block also rebuilds the ideal code from the held segments (32 per thermometer line plus the binary part) and raises a flag when the thermometer lines are not a solid run starting at line 0. A downstream checker can use these two outputs to confirm the ladder weighting.

Top module: `seg_dac_frontend`

## Requirements
- R1: While `cmp_i` is 1, the word that is encoded is the bitwise inverse of `data_i`. While `cmp_i` is 0, the word is `data_i` unchanged.
- R2: The number of asserted `therm_o` lines equals bits 7..5 of the encoded word. Asserted lines always form a contiguous run starting at line 0 (bit 0 of `therm_o`).
- R3: `bin_o` equals bits 4..0 of the encoded word, with bit 0 weighted 1.
- R4: While `le_n_i` is 0, the outputs follow the encoded input in the same cycle, with no clock of delay.
- R5: While `le_n_i` is 1, the outputs hold the word encoded at the last rising clock edge at which `le_n_i` was 0. Changes on `data_i` and `cmp_i` have no effect on them.
- R6: A synchronous active-high `rst` clears the held word, so with `le_n_i` at 1 after reset, `therm_o` and `bin_o` are all zero.
- R7: `code_o` equals 32 times the count of asserted `therm_o` lines plus `bin_o`. In transparent mode this is the encoded word itself.
- R8: `flag_o` is 1 exactly when `therm_o` is not a contiguous run from line 0. For every input it stays 0.
- R9: At each 1/8-scale step (code 32k-1 to 32k), the thermometer count rises by one and `bin_o` wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the latch enable |
| rst | input | 1 | Synchronous active-high reset of the held word |
| data_i | input | 8 | Input code, bit 7 most significant |
| cmp_i | input | 1 | 1 inverts every data bit before encoding |
| le_n_i | input | 1 | Active-low latch enable: 0 transparent, 1 hold |
| therm_o | output | 7 | Equal-weight segment lines for the upper bits |
| bin_o | output | 5 | Binary-weighted lower bits |
| code_o | output | 8 | Code rebuilt from the output segments |
| flag_o | output | 1 | Thermometer lines not contiguous from line 0 |

## Verification
The bench builds the block with its default widths: an 8-bit word split into three segment bits and five binary bits. That keeps the whole code space at 256 values, so every input code is swept in transparent mode with both complement settings. Every 1/8-scale boundary is also crossed in both directions. The hold tests freeze a word and then change the data and the complement control underneath it. A reset is applied while the block is holding, to show that the cleared word reaches the ports.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

    // Word geometry: total bits, and how many top bits drive segments
    localparam int DATA_W  = 8;
    localparam int SEG_W   = 3;
    localparam int LSB_W   = DATA_W - SEG_W;
    localparam int THERM_W = (1 << SEG_W) - 1;

    // One encoded word as the ladder drivers see it
    typedef struct packed {
        logic [THERM_W-1:0] therm;
        logic [LSB_W-1:0]   bin;
    } seg_word_t;

    localparam seg_word_t SEG_ZERO = '{therm: '0, bin: '0};

    // Count of asserted segment lines
    function automatic logic [SEG_W-1:0] seg_count(input logic [THERM_W-1:0] v);
        logic [SEG_W-1:0] n;
        n = '0;
        for (int i = 0; i < THERM_W; i++) begin
            n = n + {{(SEG_W-1){1'b0}}, v[i]};
        end
        return n;
    endfunction

    // True when v has the form 0..01..1 (possibly empty)
    function automatic logic seg_is_run(input logic [THERM_W-1:0] v);
        return ((v + THERM_W'(1)) & v) == '0;
    endfunction

endpackage

// File: rtl/seg_dac_encode.sv
module seg_dac_encode
    import seg_dac_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic              invert,
    output seg_word_t         seg
);
    logic [DATA_W-1:0] eff;
    logic [SEG_W-1:0]  top;

    assign eff = data ^ {DATA_W{invert}};
    assign top = eff[DATA_W-1 -: SEG_W];

    // Line i is lit when the segment value exceeds i
    for (genvar i = 0; i < THERM_W; i++) begin : g_line
        assign seg.therm[i] = (int'(top) > i);
    end

    assign seg.bin = eff[LSB_W-1:0];
endmodule

// File: rtl/seg_dac_hold.sv
module seg_dac_hold
    import seg_dac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      open_en,
    input  seg_word_t live,
    output seg_word_t seg
);
    seg_word_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= SEG_ZERO;
        end else if (open_en) begin
            held <= live;
        end
    end

    assign seg = open_en ? live : held;
endmodule

// File: rtl/seg_dac_rebuild.sv
module seg_dac_rebuild
    import seg_dac_pkg::*;
(
    input  seg_word_t         seg,
    output logic [DATA_W-1:0] code,
    output logic              bad_run
);
    logic [SEG_W-1:0] cnt;

    always_comb begin
        cnt     = seg_count(seg.therm);
        code    = {cnt, seg.bin};
        bad_run = !seg_is_run(seg.therm);
    end
endmodule

// File: rtl/seg_dac_frontend.sv
module seg_dac_frontend
    import seg_dac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               cmp_i,
    input  logic               le_n_i,
    output logic [THERM_W-1:0] therm_o,
    output logic [LSB_W-1:0]   bin_o,
    output logic [DATA_W-1:0]  code_o,
    output logic               flag_o
);
    seg_word_t live_seg;
    seg_word_t out_seg;

    seg_dac_encode u_enc (
        .data   (data_i),
        .invert (cmp_i),
        .seg    (live_seg)
    );

    seg_dac_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .open_en (!le_n_i),
        .live    (live_seg),
        .seg     (out_seg)
    );

    seg_dac_rebuild u_rb (
        .seg     (out_seg),
        .code    (code_o),
        .bad_run (flag_o)
    );

    assign therm_o = out_seg.therm;
    assign bin_o   = out_seg.bin;
endmodule

// File: rtl/seg_dac_frontend_chk.sv
module seg_dac_frontend_chk
    import seg_dac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  data_i,
    input logic               cmp_i,
    input logic               le_n_i,
    input logic [THERM_W-1:0] therm_o,
    input logic [LSB_W-1:0]   bin_o,
    input logic [DATA_W-1:0]  code_o,
    input logic               flag_o
);
    logic [DATA_W-1:0] eff_w;
    assign eff_w = cmp_i ? ~data_i : data_i;

    p_comp_r1: assert property (@(posedge clk) disable iff (rst)
        (!le_n_i && cmp_i) |-> (code_o == ~data_i));

    p_therm_run_r2: assert property (@(posedge clk) disable iff (rst)
        ((therm_o & (therm_o + THERM_W'(1))) == '0));

    p_bin_pass_r3: assert property (@(posedge clk) disable iff (rst)
        !le_n_i |-> (bin_o == eff_w[LSB_W-1:0]));

    p_transparent_r4: assert property (@(posedge clk) disable iff (rst)
        !le_n_i |-> (code_o == eff_w));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (le_n_i && $past(le_n_i) && !$past(rst)) |-> ($stable(therm_o) && $stable(bin_o)));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && le_n_i) |-> (therm_o == '0 && bin_o == '0));

    p_weight_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(code_o[DATA_W-1 -: SEG_W]) == $countones(therm_o)));

    p_flag_low_r8: assert property (@(posedge clk) disable iff (rst)
        !flag_o);
endmodule

bind seg_dac_frontend seg_dac_frontend_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .data_i  (data_i),
    .cmp_i   (cmp_i),
    .le_n_i  (le_n_i),
    .therm_o (therm_o),
    .bin_o   (bin_o),
    .code_o  (code_o),
    .flag_o  (flag_o)
);

// File: tb/seg_dac_frontend_bench.sv
`timescale 1ns/1ps
module seg_dac_frontend_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] data_i = 8'h00;
    logic       cmp_i = 1'b0;
    logic       le_n_i = 1'b1;
    logic [6:0] therm_o;
    logic [4:0] bin_o;
    logic [7:0] code_o;
    logic       flag_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    int held  = 0;   // reference model of the frozen word

    always #2.5 clk = ~clk;

    seg_dac_frontend u_seg_dac_frontend (
        .clk(clk), .rst(rst), .data_i(data_i), .cmp_i(cmp_i), .le_n_i(le_n_i),
        .therm_o(therm_o), .bin_o(bin_o), .code_o(code_o), .flag_o(flag_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, compare, then advance the model
    task automatic step(input logic [7:0] d, input logic c, input logic l,
                        input logic r, input string tag);
        int eff;
        int word;
        @(negedge clk);
        data_i = d; cmp_i = c; le_n_i = l; rst = r;
        #1;
        eff  = c ? (~int'(d) & 255) : int'(d);
        word = l ? held : eff;
        if (!r) begin
            check(tag, "therm", 32'(therm_o), 32'((1 << (word / 32)) - 1));
            check(tag, "bin",   32'(bin_o),   32'(word % 32));
            check(tag, "code",  32'(code_o),  32'(word));
            check(tag, "flag",  32'(flag_o),  32'd0);
        end
        @(posedge clk);
        if (r) held = 0;
        else if (!l) held = eff;
    endtask

    initial begin
        // R6: reset with enable high, then outputs read zero
        step(8'h5A, 1'b0, 1'b1, 1'b1, "R6");
        step(8'h5A, 1'b0, 1'b1, 1'b1, "R6");
        step(8'hC3, 1'b0, 1'b1, 1'b0, "R6");

        // R2 R3 R4 R7 R8: every code, transparent, no inversion
        for (int k = 0; k < 256; k++) step(8'(k), 1'b0, 1'b0, 1'b0, "R4");

        // R1: every code with inversion
        for (int k = 0; k < 256; k++) step(8'(k), 1'b1, 1'b0, 1'b0, "R1");

        // R9: cross each 1/8-scale boundary up and down
        for (int s = 1; s < 8; s++) begin
            step(8'(32*s - 1), 1'b0, 1'b0, 1'b0, "R9");
            step(8'(32*s),     1'b0, 1'b0, 1'b0, "R9");
            step(8'(32*s - 1), 1'b0, 1'b0, 1'b0, "R9");
        end

        // R5: freeze A5, then disturb data and complement
        step(8'hA5, 1'b0, 1'b0, 1'b0, "R5");
        step(8'h00, 1'b0, 1'b1, 1'b0, "R5");
        step(8'hFF, 1'b1, 1'b1, 1'b0, "R5");
        step(8'h3C, 1'b0, 1'b1, 1'b0, "R5");
        if (code_o !== 8'hA5) check("R5", "frozen", 32'(code_o), 32'hA5);
        // reopen with inversion, freeze again
        step(8'h12, 1'b1, 1'b0, 1'b0, "R5");
        step(8'h77, 1'b0, 1'b1, 1'b0, "R5");
        step(8'h00, 1'b1, 1'b1, 1'b0, "R5");

        // R6: reset while holding clears the frozen word
        step(8'h99, 1'b0, 1'b1, 1'b1, "R6");
        step(8'h99, 1'b0, 1'b1, 1'b0, "R6");
        step(8'hFF, 1'b1, 1'b1, 1'b0, "R6");

        // extremes in transparent mode, then frozen full scale
        step(8'hFF, 1'b0, 1'b0, 1'b0, "R7");
        step(8'h00, 1'b0, 1'b1, 1'b0, "R7");
        step(8'hFF, 1'b1, 1'b0, 1'b0, "R7");

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule